// File: doc/BRIEF.md
# Mixed-Radix Display Address Counter

This block generates the address of a character cell in a text display memory. The address has three digits. A character digit counts 0 to 19. A block digit counts 0 to 3. A row digit counts 0 to 11. On each enabled clock edge the character digit steps up or down by one. When a digit wraps in the direction it is counting, the wrap passes to another digit. A two-bit cascade mode sets which digit receives it. The mode can chain all three digits in either order, or it can tie the character digit to only one of the others.

A parallel load presets all three digits in one cycle. The value comes from one of three sources: the cursor position inputs, the scroll start inputs, or a fixed constant that puts the row digit at its top value. A synchronous clear zeroes the whole address. Two flags show the character digit at its last column and the block digit at its last block. Logic outside the block decides when to load, clear or count.

Top module: `mixed_radix_addr_counter`

## Requirements
- R1: After reset all three digits read 0, `char_last` is 0 and `blk_last_n` is 1.
- R2: The character digit steps once per counting cycle. Counting up goes from 19 to 0, and counting down goes from 0 to 19.
- R3: The row digit counts 0 to 11. Counting up goes from 11 to 0. Counting down from 0 gives 11 and then carries on downward from 11.
- R4: The block digit counts 0 to 3. Counting up goes from 3 to 0, and counting down goes from 0 to 3.
- R5: In cascade mode 0 the order is character, then block, then row. A digit steps only in a cycle where every digit before it in the chain is at its wrap value for the current direction.
- R6: In cascade mode 1 the order is character, then row, then block.
- R7: In cascade mode 2 only the block digit follows the character digit, and the row digit holds. In mode 3 only the row digit follows, and the block digit holds.
- R8: A cycle with both `step_up` and `step_dn` high, or with neither high, leaves all digits unchanged.
- R9: `clear` zeroes all digits on the next edge. It overrides `load` and counting.
- R10: `load` overrides counting. Source code 0 loads the cursor fields into all three digits. Code 1 loads 0 into the character digit and the scroll fields into the block and row digits. Codes 2 and 3 load 0, 0 and 11. Loaded values are assumed to lie within each digit's range.
- R11: `char_last` is high exactly when the character digit holds 19.
- R12: `blk_last_n` is low exactly when the block digit holds 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_up | input | 1 | Count up |
| step_dn | input | 1 | Count down |
| load | input | 1 | Parallel load from the selected source |
| clear | input | 1 | Zero all digits |
| cas_mode | input | 2 | Cascade mode (0 to 3, see R5 to R7) |
| load_src | input | 2 | Load source (0 cursor, 1 scroll, 2 or 3 constant) |
| cur_char | input | 5 | Cursor character position |
| cur_blk | input | 2 | Cursor block position |
| cur_row | input | 4 | Cursor row position |
| scr_blk | input | 2 | Scroll start block |
| scr_row | input | 4 | Scroll start row |
| char_q | output | 5 | Character digit |
| blk_q | output | 2 | Block digit |
| row_q | output | 4 | Row digit |
| char_last | output | 1 | High when the character digit is 19 |
| blk_last_n | output | 1 | Low when the block digit is 3 |

## Verification
All digits are registers. Every count, load or clear therefore appears on the outputs one edge after the inputs are applied. The two flags are decoded from those registers, so they follow in the same cycle as the digit values. The bench applies inputs just after a falling edge. It updates its model at the next rising edge and compares every output at the falling edge that follows, which is exactly one edge after the stimulus. Long runs of counting in each mode and in both directions cover every wrap, including the full 960-state wrap of the address.

// File: rtl/addr_ctr_pkg.sv
package addr_ctr_pkg;
   typedef enum logic [1:0] {
      CAS_BLK_ROW  = 2'd0,
      CAS_ROW_BLK  = 2'd1,
      CAS_BLK_ONLY = 2'd2,
      CAS_ROW_ONLY = 2'd3
   } cascade_e;

   typedef enum logic [1:0] {
      SRC_CURSOR = 2'd0,
      SRC_SCROLL = 2'd1,
      SRC_CONST  = 2'd2,
      SRC_CONST2 = 2'd3
   } load_src_e;
endpackage

// File: rtl/addr_digit.sv
module addr_digit #(
   parameter int RADIX = 12,
   localparam int W = $clog2(RADIX)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         up,
   output logic [W-1:0] q,
   output logic         at_wrap
);
   localparam logic [W-1:0] TOP = W'(RADIX - 1);

   logic [W-1:0] nxt;

   if (RADIX < 2) begin : g_bad_radix
      $error("addr_digit: RADIX must be at least 2");
   end

   if ((1 << W) == RADIX) begin : g_natural
      always_comb nxt = up ? q + W'(1) : q - W'(1);
   end else begin : g_truncated
      logic [W-1:0] inc, dec;
      always_comb begin
         inc = q + W'(1);
         dec = q - W'(1);
         if (up) nxt = (inc == W'(RADIX)) ? '0 : inc;
         else    nxt = (dec == '1) ? TOP : dec;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (clear) q <= '0;
      else if (load)  q <= load_val;
      else if (step)  q <= nxt;
   end

   assign at_wrap = up ? (q == TOP) : (q == '0);

   // R3
   range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q <= TOP);
   // R2
   wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && up && !clear && !load && q == TOP) |=> q == '0);
   // R3
   wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !up && !clear && !load && q == '0) |=> q == TOP);
   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clear && !load) |=> $stable(q));
endmodule

// File: rtl/addr_cascade.sv
module addr_cascade
   import addr_ctr_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       go,
   input  logic       char_wrap,
   input  logic       blk_wrap,
   input  logic       row_wrap,
   output logic       char_step,
   output logic       blk_step,
   output logic       row_step
);
   cascade_e m;
   logic     c_out;

   always_comb begin
      m         = cascade_e'(mode);
      char_step = go;
      c_out     = go && char_wrap;
      blk_step  = 1'b0;
      row_step  = 1'b0;
      unique case (m)
         CAS_BLK_ROW: begin
            blk_step = c_out;
            row_step = c_out && blk_wrap;
         end
         CAS_ROW_BLK: begin
            row_step = c_out;
            blk_step = c_out && row_wrap;
         end
         CAS_BLK_ONLY: blk_step = c_out;
         CAS_ROW_ONLY: row_step = c_out;
         default: ;
      endcase
   end
endmodule

// File: rtl/addr_load_mux.sv
module addr_load_mux
   import addr_ctr_pkg::*;
#(
   parameter int CW = 5,
   parameter int BW = 2,
   parameter int RW = 4,
   parameter int ROW_CONST = 11
) (
   input  logic [1:0]    src,
   input  logic [CW-1:0] cur_char,
   input  logic [BW-1:0] cur_blk,
   input  logic [RW-1:0] cur_row,
   input  logic [BW-1:0] scr_blk,
   input  logic [RW-1:0] scr_row,
   output logic [CW-1:0] lv_char,
   output logic [BW-1:0] lv_blk,
   output logic [RW-1:0] lv_row
);
   load_src_e s;

   always_comb begin
      s = load_src_e'(src);
      unique case (s)
         SRC_CURSOR: begin
            lv_char = cur_char;
            lv_blk  = cur_blk;
            lv_row  = cur_row;
         end
         SRC_SCROLL: begin
            lv_char = '0;
            lv_blk  = scr_blk;
            lv_row  = scr_row;
         end
         default: begin
            lv_char = '0;
            lv_blk  = '0;
            lv_row  = RW'(ROW_CONST);
         end
      endcase
   end
endmodule

// File: rtl/mixed_radix_addr_counter.sv
module mixed_radix_addr_counter
   import addr_ctr_pkg::*;
#(
   parameter int CHAR_RADIX = 20,
   parameter int BLK_RADIX  = 4,
   parameter int ROW_RADIX  = 12,
   localparam int CW = $clog2(CHAR_RADIX),
   localparam int BW = $clog2(BLK_RADIX),
   localparam int RW = $clog2(ROW_RADIX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_up,
   input  logic          step_dn,
   input  logic          load,
   input  logic          clear,
   input  logic [1:0]    cas_mode,
   input  logic [1:0]    load_src,
   input  logic [CW-1:0] cur_char,
   input  logic [BW-1:0] cur_blk,
   input  logic [RW-1:0] cur_row,
   input  logic [BW-1:0] scr_blk,
   input  logic [RW-1:0] scr_row,
   output logic [CW-1:0] char_q,
   output logic [BW-1:0] blk_q,
   output logic [RW-1:0] row_q,
   output logic          char_last,
   output logic          blk_last_n
);
   localparam int ROW_CONST = ROW_RADIX - 1;

   logic go, up;
   logic char_wrap, blk_wrap, row_wrap;
   logic char_step, blk_step, row_step;
   logic [CW-1:0] lv_char;
   logic [BW-1:0] lv_blk;
   logic [RW-1:0] lv_row;

   if (CHAR_RADIX < 2 || BLK_RADIX < 2 || ROW_RADIX < 2) begin : g_bad_cfg
      $error("mixed_radix_addr_counter: every radix must be at least 2");
   end

   assign go = (step_up ^ step_dn) && !load && !clear;
   assign up = step_up;

   addr_cascade u_cascade (
      .mode(cas_mode), .go(go),
      .char_wrap(char_wrap), .blk_wrap(blk_wrap), .row_wrap(row_wrap),
      .char_step(char_step), .blk_step(blk_step), .row_step(row_step)
   );

   addr_load_mux #(.CW(CW), .BW(BW), .RW(RW), .ROW_CONST(ROW_CONST)) u_mux (
      .src(load_src), .cur_char(cur_char), .cur_blk(cur_blk), .cur_row(cur_row),
      .scr_blk(scr_blk), .scr_row(scr_row),
      .lv_char(lv_char), .lv_blk(lv_blk), .lv_row(lv_row)
   );

   addr_digit #(.RADIX(CHAR_RADIX)) u_char (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .load_val(lv_char),
      .step(char_step), .up(up), .q(char_q), .at_wrap(char_wrap)
   );

   addr_digit #(.RADIX(BLK_RADIX)) u_blk (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .load_val(lv_blk),
      .step(blk_step), .up(up), .q(blk_q), .at_wrap(blk_wrap)
   );

   addr_digit #(.RADIX(ROW_RADIX)) u_row (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .load_val(lv_row),
      .step(row_step), .up(up), .q(row_q), .at_wrap(row_wrap)
   );

   assign char_last  = (char_q == CW'(CHAR_RADIX - 1));
   assign blk_last_n = (blk_q != BW'(BLK_RADIX - 1));

   // R9
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (char_q == '0 && blk_q == '0 && row_q == '0));
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !load && step_up == step_dn) |=>
         ($stable(char_q) && $stable(blk_q) && $stable(row_q)));
   // R10
   const_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clear && load_src[1]) |=> (row_q == RW'(ROW_CONST) && char_q == '0));
   // R11
   last_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && step_up && char_q == CW'(CHAR_RADIX - 2)) |=> char_last);
   // R12
   last_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load && load_src == 2'd0 && cur_blk == BW'(BLK_RADIX - 1)) |=> !blk_last_n);
   // R5
   full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && step_up && cas_mode == 2'd0 && char_last && !blk_last_n &&
       row_q == RW'(ROW_CONST)) |=> (char_q == '0 && blk_q == '0 && row_q == '0));
   // R7
   row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !load && cas_mode == 2'd2) |=> $stable(row_q));
endmodule

// File: tb/tb_mixed_radix_addr_counter.sv
module tb_mixed_radix_addr_counter;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic step_up = 0, step_dn = 0, load = 0, clear = 0;
   logic [1:0] cas_mode = 0, load_src = 0;
   logic [4:0] cur_char = 0;
   logic [1:0] cur_blk = 0, scr_blk = 0;
   logic [3:0] cur_row = 0, scr_row = 0;
   logic [4:0] char_q;
   logic [1:0] blk_q;
   logic [3:0] row_q;
   logic char_last, blk_last_n;

   int tests = 0, fails = 0, cycles = 0;
   int mc = 0, mb = 0, mr = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mixed_radix_addr_counter dut (
      .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
      .load(load), .clear(clear), .cas_mode(cas_mode), .load_src(load_src),
      .cur_char(cur_char), .cur_blk(cur_blk), .cur_row(cur_row),
      .scr_blk(scr_blk), .scr_row(scr_row),
      .char_q(char_q), .blk_q(blk_q), .row_q(row_q),
      .char_last(char_last), .blk_last_n(blk_last_n)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "char", int'(char_q), mc);
      chk(tag, "blk", int'(blk_q), mb);
      chk(tag, "row", int'(row_q), mr);
      chk("R11", "char_last", int'(char_last), int'(mc == 19));
      chk("R12", "blk_last_n", int'(blk_last_n), int'(mb != 3));
   endtask

   task automatic bump(inout int v, input int radix, input bit u, output bit w);
      w = 0;
      if (u) begin
         v++;
         if (v == radix) begin v = 0; w = 1; end
      end else begin
         if (v == 0) begin v = radix - 1; w = 1; end
         else v--;
      end
   endtask

   task automatic model;
      bit w1, w2;
      if (clear) begin
         mc = 0; mb = 0; mr = 0;
      end else if (load) begin
         case (load_src)
            2'd0: begin mc = cur_char; mb = cur_blk; mr = cur_row; end
            2'd1: begin mc = 0; mb = scr_blk; mr = scr_row; end
            default: begin mc = 0; mb = 0; mr = 11; end
         endcase
      end else if (step_up != step_dn) begin
         bump(mc, 20, step_up, w1);
         if (w1) begin
            case (cas_mode)
               2'd0: begin bump(mb, 4, step_up, w2); if (w2) bump(mr, 12, step_up, w2); end
               2'd1: begin bump(mr, 12, step_up, w2); if (w2) bump(mb, 4, step_up, w2); end
               2'd2: bump(mb, 4, step_up, w2);
               default: bump(mr, 12, step_up, w2);
            endcase
         end
      end
   endtask

   task automatic cyc(input bit u, input bit d, input bit ld, input bit cl,
                      input logic [1:0] md, input logic [1:0] src, input string tag);
      step_up = u; step_dn = d; load = ld; clear = cl; cas_mode = md; load_src = src;
      @(posedge clk);
      model();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic run(input int n, input bit u, input bit d, input logic [1:0] md, input string tag);
      for (int i = 0; i < n; i++) cyc(u, d, 0, 0, md, 0, tag);
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            finish_up();
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "char", int'(char_q), 0);
      chk("R1", "blk", int'(blk_q), 0);
      chk("R1", "row", int'(row_q), 0);
      chk("R1", "char_last", int'(char_last), 0);
      chk("R1", "blk_last_n", int'(blk_last_n), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 character digit wraps both ways (block-only mode)
      run(45, 1, 0, 2'd2, "R2");
      run(45, 0, 1, 2'd2, "R2");
      // R4 block digit wraps both ways
      run(100, 1, 0, 2'd2, "R4");
      run(100, 0, 1, 2'd2, "R4");
      // R3 row digit wraps both ways (row-only mode)
      run(260, 1, 0, 2'd3, "R3");
      run(260, 0, 1, 2'd3, "R3");
      // R5 full chain character, block, row
      cyc(0, 0, 0, 1, 2'd0, 0, "R9");
      run(1000, 1, 0, 2'd0, "R5");
      run(1000, 0, 1, 2'd0, "R5");
      // R6 chain character, row, block
      run(1000, 1, 0, 2'd1, "R6");
      run(500, 0, 1, 2'd1, "R6");
      // R7 row held in mode 2, block held in mode 3
      cur_char = 7; cur_blk = 2; cur_row = 5;
      cyc(0, 0, 1, 0, 2'd2, 2'd0, "R10");
      run(100, 1, 0, 2'd2, "R7");
      cyc(0, 0, 1, 0, 2'd3, 2'd0, "R10");
      run(100, 0, 1, 2'd3, "R7");
      // R8 both or neither direction
      run(10, 1, 1, 2'd0, "R8");
      run(10, 0, 0, 2'd1, "R8");
      // R9 clear over load and count
      cyc(1, 0, 1, 1, 2'd0, 2'd2, "R9");
      // R10 each source, load over count
      scr_blk = 3; scr_row = 9; cur_char = 19; cur_blk = 3; cur_row = 11;
      cyc(1, 0, 1, 0, 2'd0, 2'd0, "R10");
      cyc(0, 1, 1, 0, 2'd0, 2'd1, "R10");
      cyc(1, 0, 1, 0, 2'd0, 2'd2, "R10");
      cyc(0, 1, 1, 0, 2'd0, 2'd3, "R10");
      run(3, 0, 1, 2'd1, "R3");

      // mixed stimulus
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom;
         cur_char = 5'($urandom_range(19, 0));
         cur_blk  = 2'($urandom_range(3, 0));
         cur_row  = 4'($urandom_range(11, 0));
         scr_blk  = 2'($urandom_range(3, 0));
         scr_row  = 4'($urandom_range(11, 0));
         cyc(r[0], r[1], (r[7:2] == 0), (r[13:8] == 0), r[15:14], r[17:16], "R10");
      end

      finish_up();
   end
endmodule